// File: doc/BRIEF.md
# Residue-domain divide-by-2^N scaler for the moduli {2^(N+1)-1, 2^N, 2^N-1}

The block takes a number held as three residues, one for each of the moduli m1 = 2^(N+1)-1, m2 = 2^N and m3 = 2^N-1. It returns the three residues of floor(X/2^N), where X in [0, m1*m2*m3) is the integer the input triple stands for. It never rebuilds X in binary.

The three channels are computed side by side from closed forms derived from the Chinese remainder theorem:
- The first channel doubles R1-R2 modulo m1.
- The third channel takes R3-R2 modulo m3.
- The middle channel subtracts the low N bits of an auxiliary value A = |2R2 + 2R3 - 4R1|_m1 from |R3-R2|_2^N.
- A one-bit correction v is added into the middle-channel subtractor. It is set when A is zero and R3 is below R2.

The outputs are registered, so results appear one clock after the inputs are taken. The block is used in residue arithmetic pipelines to bring an accumulated value back into range.

Top module: `rns_pow2_scaler`

## Requirements
- R1: While rst is high at a rising clock edge, r1s, r2s and r3s become 0 at that edge.
- R2: Each output is registered. The value the inputs hold at a rising edge appears at the outputs after that edge and stays until the next edge.
- R3: r1s equals floor(X/2^N) mod (2^(N+1)-1). Its all-ones code never appears.
- R4: r2s equals floor(X/2^N) mod 2^N when the correction bit is 0.
- R5: r3s equals floor(X/2^N) mod (2^N-1). Its all-ones code never appears.
- R6: An r1_in value of all ones (2^(N+1)-1) gives exactly the same outputs as r1_in = 0.
- R7: Let A = |2*r2_in + 2*r3_in - 4*r1_in| mod (2^(N+1)-1). When A = 0 and r3_in < r2_in, r2s still equals floor(X/2^N) mod 2^N, which is then (r3s + 2) mod 2^N.
- R8: Equal inputs r1_in = r2_in give r1s = 0. Equal inputs r3_in = r2_in give r3s = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r1_in | input | N+1 | Residue modulo 2^(N+1)-1; the all-ones code is read as 0 |
| r2_in | input | N | Residue modulo 2^N |
| r3_in | input | N | Residue modulo 2^N-1 |
| r1s | output | N+1 | Scaled residue modulo 2^(N+1)-1 |
| r2s | output | N | Scaled residue modulo 2^N |
| r3s | output | N | Scaled residue modulo 2^N-1 |

## Verification
The hardest case to reach is the correction path. It needs the auxiliary sum to fold to exactly zero modulo m1 while R3 lies below R2, and few triples satisfy both. It only shows up in the middle output as a one-count offset.

The stimulus therefore walks every integer X in the range for a small width and derives the residues from X itself. This reaches every valid triple, including all correction cases, with no search for them. The same walk is repeated on the multiples of m1, with r1_in driven as all ones, to cover the alias code. A wider instance is exercised with random X plus the range ends.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;
  typedef enum logic {
    CORR_NONE = 1'b0,
    CORR_WRAP = 1'b1
  } corr_e;
endpackage

// File: rtl/mers_add.sv
module mers_add #(
  parameter int K = 5
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic [K-1:0] y
);
  logic [K:0]   raw;
  logic [K-1:0] fold;

  always_comb begin
    raw  = {1'b0, a} + {1'b0, b};
    fold = raw[K-1:0] + K'(raw[K]);
    y    = (&fold) ? '0 : fold;
  end
endmodule

// File: rtl/mers_sub.sv
module mers_sub #(
  parameter int K = 5
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic [K-1:0] y
);
  logic [K-1:0] b_neg;

  assign b_neg = ~b;

  mers_add #(.K(K)) u_add (
    .a(a),
    .b(b_neg),
    .y(y)
  );
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int K = 5
) (
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic [K-1:0] z,
  output logic [K-1:0] s,
  output logic [K-1:0] c_rot
);
  logic [K-1:0] c;

  for (genvar i = 0; i < K; i++) begin : g_fa
    assign s[i] = x[i] ^ y[i] ^ z[i];
    assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end

  // weight-2 carries wrap around modulo 2^K-1
  assign c_rot = {c[K-2:0], c[K-1]};
endmodule

// File: rtl/pow2_sub.sv
module pow2_sub #(
  parameter int K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  input  logic         cin,
  output logic [K-1:0] y
);
  assign y = a + (~b) + K'(1) + K'(cin);
endmodule

// File: rtl/rns_pow2_scaler.sv
module rns_pow2_scaler
  import rns_scale_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N:0]   r1_in,
  input  logic [N-1:0] r2_in,
  input  logic [N-1:0] r3_in,
  output logic [N:0]   r1s,
  output logic [N-1:0] r2s,
  output logic [N-1:0] r3s
);
  localparam int W1 = N + 1;

  logic [W1-1:0] r2_ext;
  logic [W1-1:0] diff1;
  logic [W1-1:0] r1s_d;
  logic [W1-1:0] op_a, op_b, op_c;
  logic [W1-1:0] csa_s, csa_c;
  logic [W1-1:0] aux;
  logic [N-1:0]  diff3;
  logic [N-1:0]  diff2;
  logic [N-1:0]  r2s_d;
  corr_e         corr;

  assign r2_ext = {1'b0, r2_in};

  // channel m1: 2*(R1-R2)
  mers_sub #(.K(W1)) u_diff1 (.a(r1_in), .b(r2_ext), .y(diff1));
  assign r1s_d = {diff1[W1-2:0], diff1[W1-1]};

  // auxiliary A = -4R1 + 2R2 + 2R3 mod m1
  assign op_a = ~{r1_in[W1-3:0], r1_in[W1-1:W1-2]};
  assign op_b = {r2_in, 1'b0};
  assign op_c = {r3_in, 1'b0};

  csa_row #(.K(W1)) u_csa (
    .x(op_a), .y(op_b), .z(op_c), .s(csa_s), .c_rot(csa_c)
  );

  mers_add #(.K(W1)) u_aux (.a(csa_s), .b(csa_c), .y(aux));

  // channel m3
  mers_sub #(.K(N)) u_diff3 (.a(r3_in), .b(r2_in), .y(diff3));

  // channel m2
  pow2_sub #(.K(N)) u_diff2 (.a(r3_in), .b(r2_in), .cin(1'b0), .y(diff2));

  assign corr = ((aux == '0) && (r3_in < r2_in)) ? CORR_WRAP : CORR_NONE;

  pow2_sub #(.K(N)) u_mid (
    .a(diff2), .b(aux[N-1:0]), .cin(corr == CORR_WRAP), .y(r2s_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r1s <= '0;
      r2s <= '0;
      r3s <= '0;
    end else begin
      r1s <= r1s_d;
      r2s <= r2s_d;
      r3s <= diff3;
    end
  end

  // R3: first channel never shows the all-ones alias
  a_r3_no_alias: assert property (@(posedge clk) disable iff (rst)
    r1s != {W1{1'b1}});

  // R5: third channel never shows the all-ones alias
  a_r5_no_alias: assert property (@(posedge clk) disable iff (rst)
    r3s != {N{1'b1}});

  // R8: equal R1/R2 yields zero in channel m1
  a_r8_equal_first: assert property (@(posedge clk) disable iff (rst)
    (r1_in == r2_ext) |=> (r1s == '0));

  // R8: equal R3/R2 yields zero in channel m3
  a_r8_equal_third: assert property (@(posedge clk) disable iff (rst)
    (r3_in == r2_in) |=> (r3s == '0));

  // R6: alias code in R1 with R2 = 0 gives zero in channel m1
  a_r6_alias_zero: assert property (@(posedge clk) disable iff (rst)
    ((&r1_in) && (r2_in == '0)) |=> (r1s == '0));

  // R7: correction case ties middle output to third output
  a_r7_corr_link: assert property (@(posedge clk) disable iff (rst)
    (corr == CORR_WRAP) |=> (r2s == N'(r3s + N'(2))));
endmodule

// File: tb/sim_rns_pow2_scaler.sv
module sim_rns_pow2_scaler;
  localparam int NA = 4;
  localparam int NB = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NA:0]   a_r1 = '0;
  logic [NA-1:0] a_r2 = '0, a_r3 = '0;
  logic [NA:0]   a_q1;
  logic [NA-1:0] a_q2, a_q3;
  logic [NB:0]   b_r1 = '0;
  logic [NB-1:0] b_r2 = '0, b_r3 = '0;
  logic [NB:0]   b_q1;
  logic [NB-1:0] b_q2, b_q3;

  int total = 0;
  int bad = 0;

  rns_pow2_scaler #(.N(NA)) u0 (
    .clk(clk), .rst(rst), .r1_in(a_r1), .r2_in(a_r2), .r3_in(a_r3),
    .r1s(a_q1), .r2s(a_q2), .r3s(a_q3)
  );

  rns_pow2_scaler #(.N(NB)) u1 (
    .clk(clk), .rst(rst), .r1_in(b_r1), .r2_in(b_r2), .r3_in(b_r3),
    .r1s(b_q1), .r2s(b_q2), .r3s(b_q3)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void calc(input int n, input longint x,
                               output longint r1, output longint r2,
                               output longint r3, output longint e1,
                               output longint e2, output longint e3,
                               output bit vb);
    longint m1, m2, m3, sc, av;
    m1 = (longint'(1) << (n + 1)) - 1;
    m2 = longint'(1) << n;
    m3 = m2 - 1;
    r1 = x % m1;
    r2 = x % m2;
    r3 = x % m3;
    sc = x >> n;
    e1 = sc % m1;
    e2 = sc % m2;
    e3 = sc % m3;
    av = (2 * r2 + 2 * r3 + 4 * (m1 - r1)) % m1;
    vb = (av == 0) && (r3 < r2);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic run_a(input longint x, input bit use_alias);
    longint r1, r2, r3, e1, e2, e3;
    bit vb;
    string t1, t2, t3;
    calc(NA, x, r1, r2, r3, e1, e2, e3, vb);
    if (use_alias && r1 == 0) r1 = (longint'(1) << (NA + 1)) - 1;
    a_r1 = (NA+1)'(r1);
    a_r2 = NA'(r2);
    a_r3 = NA'(r3);
    @(posedge clk);
    #1;
    t1 = use_alias ? "R6" : "R3";
    t2 = use_alias ? "R6" : (vb ? "R7" : "R4");
    t3 = use_alias ? "R6" : "R5";
    chk(t1, "r1s", longint'(a_q1), e1);
    chk(t2, "r2s", longint'(a_q2), e2);
    chk(t3, "r3s", longint'(a_q3), e3);
    @(negedge clk);
  endtask

  task automatic run_b(input longint x);
    longint r1, r2, r3, e1, e2, e3;
    bit vb;
    calc(NB, x, r1, r2, r3, e1, e2, e3, vb);
    b_r1 = (NB+1)'(r1);
    b_r2 = NB'(r2);
    b_r3 = NB'(r3);
    @(posedge clk);
    #1;
    chk("R3", "wide r1s", longint'(b_q1), e1);
    chk(vb ? "R7" : "R4", "wide r2s", longint'(b_q2), e2);
    chk("R5", "wide r3s", longint'(b_q3), e3);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ma, mb;
    longint r1, r2, r3, e1, e2, e3;
    bit vb;
    ma = ((longint'(1) << (NA + 1)) - 1) * (longint'(1) << NA) * ((longint'(1) << NA) - 1);
    mb = ((longint'(1) << (NB + 1)) - 1) * (longint'(1) << NB) * ((longint'(1) << NB) - 1);

    // R1: reset clears outputs even with live inputs
    @(negedge clk);
    a_r1 = 5'd9; a_r2 = 4'd7; a_r3 = 4'd3;
    b_r1 = 11'd100; b_r2 = 10'd55; b_r3 = 10'd9;
    @(posedge clk);
    #1;
    chk("R1", "r1s in reset", longint'(a_q1), 0);
    chk("R1", "r2s in reset", longint'(a_q2), 0);
    chk("R1", "r3s in reset", longint'(a_q3), 0);
    chk("R1", "wide r1s in reset", longint'(b_q1), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2: outputs follow the last edge and hold between edges
    run_a(longint'(1000), 1'b0);
    calc(NA, longint'(1000), r1, r2, r3, e1, e2, e3, vb);
    a_r1 = 5'd3; a_r2 = 4'd12; a_r3 = 4'd1;
    #1;
    chk("R2", "r1s held", longint'(a_q1), e1);
    chk("R2", "r2s held", longint'(a_q2), e2);
    chk("R2", "r3s held", longint'(a_q3), e3);

    // R8: equal residues
    run_a(longint'(0), 1'b0);

    // exhaustive sweep of every valid triple for the small width
    for (longint x = 0; x < ma; x++) run_a(x, 1'b0);

    // R6: alias code on r1_in for every multiple of m1
    for (longint x = 0; x < ma; x += 31) run_a(x, 1'b1);

    // wide width: ends of range plus random points
    run_b(longint'(0));
    run_b(mb - 1);
    run_b(longint'(1) << NB);
    for (int i = 0; i < 3000; i++) begin
      longint x;
      x = {$urandom, $urandom} % mb;
      if (x < 0) x = -x;
      run_b(x);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule